// File: doc/BRIEF.md
# Interrupt Controller with Holdoff Down-Counter

This block gathers single-cycle event pulses from the transmit, receive, DMA, statistics and link logic into a 16-bit cause register. It masks that register with a per-cause enable register and drives one level-sensitive interrupt line. Software uses a small register port to read the causes, clear them by writing ones, program the enable mask and load a holdoff down-counter.

The holdoff counter lets an overloaded host step back. Software disables most causes, loads the counter with a count of 3.2 us ticks and returns. When the count reaches zero the block raises its own driver-request cause, so the host is woken after the programmed interval. A clock-cycle prescaler, set by a parameter to the number of clock cycles in 3.2 us, generates the tick.

Top module: `irq_holdoff_ctrl`

## Requirements
- R1: After reset the cause register, the enable register and the holdoff count all read 0, and `irq_o` is low.
- R2: A pulse on `evt_i` sets the matching cause bit on the next clock edge for bus error (bit 1), transmit done (2), MAC control (3), receive done (4), receive start (5), statistics near overflow (7), link change (8), transmit DMA done (9) and receive DMA done (10). Pulses on bits 0, 6 and 11 to 15 are ignored, and those cause bits read 0 unless bit 6 is set by the counter.
- R3: A write to the cause register (`reg_sel` = 0) clears only the bits that are 1 in the written data. All other cause bits keep their value.
- R4: When an event pulse on a bit arrives in the same cycle as a write that clears that bit, the bit ends up set.
- R5: Bit 0 of the cause register read-back is a summary. It reads 1 exactly when some cause bit from 1 to 15 is set while its enable bit is also set.
- R6: `irq_o` is the OR of (cause AND enable) over bits 1 to 15. An enable value of 0 holds `irq_o` low whatever the causes are.
- R7: A write of a non-zero value N to the holdoff register (`reg_sel` = 2) loads the count. The count then decrements once every TICK_DIV clock cycles, and the current count reads back from the same register.
- R8: The count reaches 0 exactly N×TICK_DIV clock edges after the loading edge. On that same edge the driver-request cause (bit 6) is set. The count then stays at 0 and raises no further event.
- R9: Writing 0 to the holdoff register stops the count and raises no driver-request event.
- R10: Writing a new non-zero value while the count is running restarts the count from that value with a fresh prescaler phase.
- R11: A write to the enable register (`reg_sel` = 1) stores bits 1 to 10. The register reads back the stored value with bit 0 and bits 11 to 15 as 0. Selector 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 16 | One-cycle event pulses, one per cause bit position |
| reg_sel | input | 2 | Register select: 0 cause, 1 enable, 2 holdoff count, 3 none |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| irq_o | output | 1 | Level interrupt request |

## Verification
On every cycle, assertions check that an arriving event always wins over a clear and that a clear never disturbs bits outside its mask. They also check that the count only moves by one on a prescaler tick, that a stop leaves the count at zero, that an expiry leaves zero behind it, and that a zero enable keeps the line low. Only the bench scenarios can show the exact expiry cycle N×TICK_DIV after a load, the restart on a reload, the quiet stop after a zero write, the bit map of every event position and the summary bit under each single-bit enable. The bench sweeps all sixteen event positions and all cause/enable pairings with a small prescaler.

// File: rtl/irqh_pkg.sv
package irqh_pkg;
  localparam int STAT_W = 16;

  localparam logic [STAT_W-1:0] B_SUMMARY  = 16'h0001;
  localparam logic [STAT_W-1:0] B_BUS_ERR  = 16'h0002;
  localparam logic [STAT_W-1:0] B_TX_DONE  = 16'h0004;
  localparam logic [STAT_W-1:0] B_MAC_CTL  = 16'h0008;
  localparam logic [STAT_W-1:0] B_RX_DONE  = 16'h0010;
  localparam logic [STAT_W-1:0] B_RX_START = 16'h0020;
  localparam logic [STAT_W-1:0] B_HOLDOFF  = 16'h0040;
  localparam logic [STAT_W-1:0] B_STATS_HI = 16'h0080;
  localparam logic [STAT_W-1:0] B_LINK     = 16'h0100;
  localparam logic [STAT_W-1:0] B_TX_DMA   = 16'h0200;
  localparam logic [STAT_W-1:0] B_RX_DMA   = 16'h0400;

  // Bits held in the cause register (everything except the summary).
  localparam logic [STAT_W-1:0] CAUSE_MASK = B_BUS_ERR | B_TX_DONE | B_MAC_CTL |
                                             B_RX_DONE | B_RX_START | B_HOLDOFF |
                                             B_STATS_HI | B_LINK | B_TX_DMA | B_RX_DMA;
  // Bits that external event pulses may set.
  localparam logic [STAT_W-1:0] EXT_MASK = CAUSE_MASK & ~B_HOLDOFF;

  typedef enum logic [1:0] {
    SEL_CAUSE   = 2'd0,
    SEL_ENABLE  = 2'd1,
    SEL_HOLDOFF = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irqh_tick.sv
module irqh_tick #(
  parameter int DIV = 160
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic          pre_en;

  always_comb begin
    tick   = run && !restart && (pre_q == LAST);
    pre_en = restart || run || (pre_q != '0);
    if (restart || !run || tick) pre_d = '0;
    else                         pre_d = pre_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end

  a_r7_prescaler_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= LAST);
endmodule

// File: rtl/irqh_holdoff.sv
module irqh_holdoff #(
  parameter int CNT_W    = 16,
  parameter int TICK_DIV = 160
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             running;
  logic             tick;

  assign running = (cnt_q != '0);

  irqh_tick #(.DIV(TICK_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (running),
    .restart (load),
    .tick    (tick)
  );

  always_comb begin
    cnt_en = load || tick;
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - CNT_W'(1);
    expire = tick && (cnt_q == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  a_r7_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));
  a_r8_zero_after_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load) |=> (cnt_q == '0));
  a_r9_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0) |=> (cnt_q == '0 && !expire));
endmodule

// File: rtl/irqh_cause.sv
module irqh_cause
  import irqh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              clr_we,
  input  logic [STAT_W-1:0] clr_vec,
  output logic [STAT_W-1:0] cause
);
  logic [STAT_W-1:0] st_q, st_d;
  logic [STAT_W-1:0] set_m, clr_m;
  logic              st_en;

  always_comb begin
    set_m = set_vec & CAUSE_MASK;
    clr_m = clr_we ? clr_vec : '0;
    st_en = clr_we || (set_m != '0);
    st_d  = (st_q & ~clr_m) | set_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (st_en) st_q <= st_d;
  end

  assign cause = st_q;

  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_m != '0) |=> ((st_q & $past(set_m)) == $past(set_m)));
  a_r3_clear_only_ones: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & $past(st_q & ~clr_m)) == $past(st_q & ~clr_m)));
  a_r2_unused_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q & ~CAUSE_MASK) == '0);
endmodule

// File: rtl/irq_holdoff_ctrl.sv
module irq_holdoff_ctrl
  import irqh_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int TICK_DIV = 160
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] evt_i,
  input  logic [1:0]  reg_sel,
  input  logic        reg_we,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq_o
);
  logic              rst_meta, rst_s;
  logic [STAT_W-1:0] cause, set_vec, pend;
  logic [STAT_W-1:0] en_q, en_d;
  logic              en_we, cause_we, hold_we;
  logic [CNT_W-1:0]  count;
  logic              expire;
  reg_sel_e          sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  always_comb begin
    sel      = reg_sel_e'(reg_sel);
    cause_we = reg_we && (sel == SEL_CAUSE);
    en_we    = reg_we && (sel == SEL_ENABLE);
    hold_we  = reg_we && (sel == SEL_HOLDOFF);
    en_d     = reg_wdata & CAUSE_MASK;
    set_vec  = (evt_i & EXT_MASK) | (expire ? B_HOLDOFF : '0);
  end

  irqh_cause u_cause (
    .clk     (clk),
    .rst_n   (rst_s),
    .set_vec (set_vec),
    .clr_we  (cause_we),
    .clr_vec (reg_wdata),
    .cause   (cause)
  );

  irqh_holdoff #(.CNT_W(CNT_W), .TICK_DIV(TICK_DIV)) u_holdoff (
    .clk      (clk),
    .rst_n    (rst_s),
    .load     (hold_we),
    .load_val (reg_wdata[CNT_W-1:0]),
    .count    (count),
    .expire   (expire)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)     en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  always_comb begin
    pend  = cause & en_q & ~B_SUMMARY;
    irq_o = (pend != '0);
    case (sel)
      SEL_CAUSE:   reg_rdata = cause | (irq_o ? B_SUMMARY : '0);
      SEL_ENABLE:  reg_rdata = en_q;
      SEL_HOLDOFF: reg_rdata = 16'(count);
      default:     reg_rdata = '0;
    endcase
  end

  a_r6_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_s)
    (en_q == '0) |-> !irq_o);
  a_r11_enable_unused_zero: assert property (@(posedge clk) disable iff (!rst_s)
    (en_q & ~CAUSE_MASK) == '0);
  a_r8_expire_sets_cause: assert property (@(posedge clk) disable iff (!rst_s)
    expire |=> ((cause & B_HOLDOFF) != '0));
endmodule

// File: tb/irq_holdoff_ctrl_bench.sv
module irq_holdoff_ctrl_bench;
  localparam int DIV = 4;
  localparam logic [15:0] CAUSES = 16'h07FE;
  localparam logic [15:0] EXTS   = 16'h07BE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt_i = '0;
  logic [1:0]  reg_sel = 2'd3;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  irq_holdoff_ctrl #(.CNT_W(16), .TICK_DIV(DIV)) u_irq_holdoff_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_sel(reg_sel),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cycles);
      report();
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [15:0] v);
    reg_sel = s;
    #1 v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    reg_sel = s; reg_we = 1'b1; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic [15:0] e);
    evt_i = e;
    @(posedge clk); @(negedge clk);
    evt_i = '0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    logic [15:0] v;
    logic [15:0] st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 cause", v, 16'h0000);
    rd(2'd1, v); chk("R1 enable", v, 16'h0000);
    rd(2'd2, v); chk("R1 count", v, 16'h0000);
    chk("R1 irq", {15'd0, irq_o}, 16'h0000);

    // R2 / R3 sweep of every event position
    for (int b = 0; b < 16; b++) begin
      pulse(16'h0001 << b);
      rd(2'd0, v); chk("R2 event bit", v, (16'h0001 << b) & EXTS);
      wr(2'd0, 16'hFFFF);
      rd(2'd0, v); chk("R3 clear all", v, 16'h0000);
    end

    // R3 partial clear
    pulse(16'hFFFF);
    rd(2'd0, v); chk("R2 all events", v, EXTS);
    wr(2'd0, 16'h0014);
    rd(2'd0, v); chk("R3 partial clear", v, EXTS & ~16'h0014);

    // R4 event meets clear in the same cycle
    evt_i = 16'h0004;
    wr(2'd0, 16'h000C);
    evt_i = '0;
    st = (EXTS & ~16'h0014 & ~16'h000C) | 16'h0004;
    rd(2'd0, v); chk("R4 event wins", v, st);

    // R5 / R6 / R11 sweep single-bit enables
    for (int b = 0; b < 16; b++) begin
      logic [15:0] e;
      logic        hit;
      e = (16'h0001 << b);
      wr(2'd1, e);
      rd(2'd1, v); chk("R11 enable readback", v, e & CAUSES);
      hit = ((st & e & CAUSES) != 0);
      chk("R6 irq level", {15'd0, irq_o}, {15'd0, hit});
      rd(2'd0, v); chk("R5 summary", v, st | {15'd0, hit});
    end
    wr(2'd1, 16'hFFFF);
    rd(2'd1, v); chk("R11 enable all", v, CAUSES);
    chk("R6 irq all enabled", {15'd0, irq_o}, 16'h0001);
    wr(2'd1, 16'h0000);
    chk("R6 irq disabled", {15'd0, irq_o}, 16'h0000);
    rd(2'd0, v); chk("R5 summary disabled", v, st);
    rd(2'd3, v); chk("R11 none selector", v, 16'h0000);

    // R7 / R8 countdown of 3
    wr(2'd0, 16'hFFFF);
    wr(2'd1, 16'h0040);
    wr(2'd2, 16'd3);
    for (int k = 1; k <= 16; k++) begin
      int exp_cnt;
      step();
      exp_cnt = 3 - k / DIV;
      if (exp_cnt < 0) exp_cnt = 0;
      rd(2'd2, v); chk("R7 count value", v, 16'(exp_cnt));
      rd(2'd0, v); chk("R8 expiry cause", v, (k >= 3 * DIV) ? 16'h0041 : 16'h0000);
      chk("R8 irq on expiry", {15'd0, irq_o}, (k >= 3 * DIV) ? 16'h0001 : 16'h0000);
    end
    wr(2'd0, 16'h0040);
    repeat (10) step();
    rd(2'd0, v); chk("R8 no second event", v, 16'h0000);

    // R9 stop with zero
    wr(2'd2, 16'd5);
    repeat (7) step();
    wr(2'd2, 16'd0);
    rd(2'd2, v); chk("R9 stopped count", v, 16'h0000);
    repeat (40) step();
    rd(2'd0, v); chk("R9 no event", v, 16'h0000);
    chk("R9 irq low", {15'd0, irq_o}, 16'h0000);

    // R10 reload while running
    wr(2'd2, 16'd2);
    repeat (6) step();
    rd(2'd2, v); chk("R10 before reload", v, 16'd1);
    wr(2'd2, 16'd3);
    for (int k = 1; k <= 3 * DIV; k++) begin
      step();
      if (k == 3 * DIV - 1) begin
        rd(2'd2, v); chk("R10 count before expiry", v, 16'd1);
        rd(2'd0, v); chk("R10 no early event", v, 16'h0000);
      end
    end
    rd(2'd0, v); chk("R10 expiry after reload", v, 16'h0041);
    wr(2'd0, 16'hFFFF);

    // R7 full-width load
    wr(2'd2, 16'hFFFF);
    rd(2'd2, v); chk("R7 max load", v, 16'hFFFF);
    repeat (DIV) step();
    rd(2'd2, v); chk("R7 max first tick", v, 16'hFFFE);
    wr(2'd2, 16'd0);
    rd(2'd0, v); chk("R9 max stop no event", v, 16'h0000);

    report();
  end
endmodule